// File: doc/BRIEF.md
# SDRAM Command Sequencer with Timing Guard

This block converts a plain request stream (read or write, bank, row, column, with a valid/ready handshake) into the command sequence of a single-rank, four-bank SDRAM. It drives clock enable, the chip select / row strobe / column strobe / write enable command lines, the bank address and a 12-bit multiplexed address bus. Data capture, pad timing and clock generation are handled elsewhere.

After reset it keeps clock enable low for a programmable settling time, then raises it, closes all banks, issues two auto refreshes and programs the mode register. Every request then becomes a bank activate followed, a fixed RAS-to-CAS delay later, by a read or write with auto-precharge. A free-running interval counter asks for auto refresh. A pending refresh lets the current access finish, waits until every bank has closed, precharges all banks and then refreshes. Every minimum spacing is a parameter counted in clock cycles. Any cycle that carries no command drives the no-operation encoding.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: While reset is asserted, sd_cke is 0, req_ready is 0, and the command lines show the no-operation encoding: cs_n=0, ras_n=1, cas_n=1, we_n=1.
- R2: sd_cke stays 0 for at least INIT_CYCLES clocks after reset is released. In every cycle that carries a command other than no-operation, sd_cke is 1 in that cycle and in the cycle before it.
- R3: The first four commands after power-up are, in order: precharge with addr[10]=1, auto refresh, auto refresh, mode register set. No request is accepted before the mode register set.
- R4: The mode register set carries sd_ba=0 and sd_addr = CAS_LAT in bits [6:4], 0 in bit 3 (sequential order), 000 in bits [2:0] (burst of one), and zeros elsewhere. No command follows it for T_MRD clocks.
- R5: With cs_n=0, {ras_n,cas_n,we_n} encodes 000 mode set, 001 auto refresh, 011 activate, 101 read, 100 write, 010 precharge and 111 no-operation. Burst stop (110) is never driven, and cs_n is never 1.
- R6: A request accepted at a clock edge (req_valid and req_ready both 1) produces an activate with sd_ba=bank and sd_addr=row in the following cycle. Exactly T_RCD cycles after the activate comes a read (req_write=0) or write (req_write=1) to the same bank, with the column in addr[7:0], addr[10]=1 and all other bits 0. Requests are served in the order they were accepted.
- R7: Two activates to the same bank are at least max(T_RC, T_RAS+T_RP, T_RCD+1+T_RDL+T_RP) cycles apart.
- R8: Two activates to any banks are at least T_RRD cycles apart.
- R9: Before each auto refresh after initialisation there is a precharge with addr[10]=1, at least T_RP cycles earlier. That precharge comes only after every bank's R7 window, counted from its last activate, has elapsed.
- R10: Auto refreshes after initialisation recur every REFI clocks, within 24 clocks either way. The first comes within REFI to REFI+24 clocks after the mode register set.
- R11: No command is issued within T_RC cycles after any auto refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The offered request is taken at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_row | input | 12 | Row to open |
| req_col | input | 8 | Column to access |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe command line |
| sd_cas_n | output | 1 | Column strobe command line |
| sd_we_n | output | 1 | Write enable command line |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Multiplexed row / column / mode address |

## Verification
A bank timer loaded with the wrong value, or a stuck one, shows at the ports as an activate that arrives too close to the previous activate of the same bank. The bench flags this on the very cycle that activate appears. A refresh counter that is off shows up one interval later, as a refresh gap outside the tolerance window. A wrong state transition shows within a few cycles: a column command at the wrong distance from its activate, a reordered request, or an initialisation sequence out of order. A request that is never served is caught by the per-request wait limit.

// File: rtl/sdr_ctrl_pkg.sv
package sdr_ctrl_pkg;

  // bit order {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_BST = 4'b0110,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [3:0] {
    S_PWR, S_WAIT, S_IPRE, S_IREF1, S_IREF2, S_IMRS, S_IDLE, S_RCD, S_REF
  } sdr_state_e;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // counter preload for a wait state: spacing between issues = max(t,2)
  function automatic int wait_load(int t);
    return (t >= 2) ? t - 2 : 0;
  endfunction

  // cycles from activate until the same bank may be activated again
  function automatic int reopen_cycles(int trc, int tras, int trcd, int trdl, int trp);
    return max2(max2(trc, tras + trp), trcd + 1 + trdl + trp);
  endfunction

  // mode word: latency in [6:4], sequential order, burst of one
  function automatic logic [11:0] mode_word(int cl);
    logic [11:0] w;
    w      = '0;
    w[6:4] = 3'(cl);
    return w;
  endfunction

endpackage

// File: rtl/sdr_gap_timer.sv
module sdr_gap_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          idle
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign idle = (cnt == '0);

  // R7 (bank windows) and R8 (activate spacing): never re-armed while running
  assert_reload_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> idle) else $error("gap timer reloaded while busy");

endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
  parameter int REFI = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ack,
  output logic pending
);
  localparam int TW = $clog2(REFI);
  logic [TW-1:0] cnt;
  logic          tick;

  assign tick = enable && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= TW'(REFI - 1);
      pending <= 1'b0;
    end else begin
      if (enable) cnt <= (cnt == '0) ? TW'(REFI - 1) : cnt - 1'b1;
      if (tick)     pending <= 1'b1;
      else if (ack) pending <= 1'b0;
    end
  end

  assert_ack_needs_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> pending) else $error("refresh acknowledged with none pending");

  assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !tick) |=> !pending) else $error("refresh request not cleared");

endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdr_ctrl_pkg::*;
#(
  parameter int BANKS       = 4,
  parameter int ADDR_W      = 12,
  parameter int COL_W       = 8,
  parameter int CAS_LAT     = 3,
  parameter int T_RCD       = 2,
  parameter int T_RP        = 2,
  parameter int T_RRD       = 2,
  parameter int T_RAS       = 5,
  parameter int T_RC        = 7,
  parameter int T_RDL       = 1,
  parameter int T_MRD       = 2,
  parameter int REFI        = 1562,
  parameter int INIT_CYCLES = 20000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [$clog2(BANKS)-1:0]  req_bank,
  input  logic [ADDR_W-1:0]         req_row,
  input  logic [COL_W-1:0]          req_col,
  output logic                      sd_cke,
  output logic                      sd_cs_n,
  output logic                      sd_ras_n,
  output logic                      sd_cas_n,
  output logic                      sd_we_n,
  output logic [$clog2(BANKS)-1:0]  sd_ba,
  output logic [ADDR_W-1:0]         sd_addr
);
  localparam int BA_W    = $clog2(BANKS);
  localparam int AP_BIT  = 10;
  localparam int REOPEN  = reopen_cycles(T_RC, T_RAS, T_RCD, T_RDL, T_RP);
  localparam int CNT_MAX = max2(max2(INIT_CYCLES, T_RC), max2(max2(T_RP, T_MRD), T_RCD));
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int BW      = $clog2(REOPEN + 1);
  localparam int RW      = $clog2(T_RRD + 1);

  sdr_state_e          st, st_n, ret, ret_n;
  logic [CW-1:0]       cnt, cnt_n;
  sdr_cmd_e            cmd_q, cmd_n;
  logic [BA_W-1:0]     ba_q, ba_n;
  logic [ADDR_W-1:0]   addr_q, addr_n;
  logic                cke_q, init_done;
  logic [BA_W-1:0]     hold_bank;
  logic [COL_W-1:0]    hold_col;
  logic                hold_wr;

  // named internal events
  logic                act_fire, ref_fire, mrs_fire, pre_all_fire;
  logic [BANKS-1:0]    bank_idle;
  logic                all_idle, rrd_idle, ref_pend;

  assign all_idle  = &bank_idle;
  assign req_ready = (st == S_IDLE) && !ref_pend && bank_idle[req_bank] && rrd_idle;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    sdr_gap_timer #(.CW(BW)) u_bank_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (act_fire && (req_bank == BA_W'(b))),
      .load_val (BW'(REOPEN - 1)),
      .idle     (bank_idle[b])
    );
  end

  sdr_gap_timer #(.CW(RW)) u_rrd_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (act_fire),
    .load_val (RW'(T_RRD - 1)),
    .idle     (rrd_idle)
  );

  sdr_refresh_timer #(.REFI(REFI)) u_refi (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (init_done),
    .ack     (ref_fire),
    .pending (ref_pend)
  );

  always_comb begin
    st_n         = st;
    ret_n        = ret;
    cnt_n        = (cnt != '0) ? cnt - 1'b1 : cnt;
    cmd_n        = CMD_NOP;
    ba_n         = '0;
    addr_n       = '0;
    act_fire     = 1'b0;
    ref_fire     = 1'b0;
    mrs_fire     = 1'b0;
    pre_all_fire = 1'b0;
    case (st)
      S_PWR: if (cnt == '0) begin
        st_n  = S_WAIT;
        cnt_n = '0;
        ret_n = S_IPRE;
      end
      S_WAIT: if (cnt == '0) st_n = ret;
      S_IPRE: begin
        cmd_n          = CMD_PRE;
        addr_n[AP_BIT] = 1'b1;
        pre_all_fire   = 1'b1;
        st_n           = S_WAIT;
        cnt_n          = CW'(wait_load(T_RP));
        ret_n          = S_IREF1;
      end
      S_IREF1, S_IREF2: begin
        cmd_n = CMD_REF;
        st_n  = S_WAIT;
        cnt_n = CW'(wait_load(T_RC));
        ret_n = (st == S_IREF1) ? S_IREF2 : S_IMRS;
      end
      S_IMRS: begin
        cmd_n    = CMD_MRS;
        addr_n   = ADDR_W'(mode_word(CAS_LAT));
        mrs_fire = 1'b1;
        st_n     = S_WAIT;
        cnt_n    = CW'(wait_load(T_MRD));
        ret_n    = S_IDLE;
      end
      S_IDLE: begin
        if (ref_pend) begin
          if (all_idle) begin
            cmd_n          = CMD_PRE;
            addr_n[AP_BIT] = 1'b1;
            pre_all_fire   = 1'b1;
            st_n           = S_WAIT;
            cnt_n          = CW'(wait_load(T_RP));
            ret_n          = S_REF;
          end
        end else if (req_valid && req_ready) begin
          cmd_n    = CMD_ACT;
          ba_n     = req_bank;
          addr_n   = req_row;
          act_fire = 1'b1;
          st_n     = S_RCD;
          cnt_n    = CW'(T_RCD - 1);
        end
      end
      S_RCD: if (cnt == '0) begin
        cmd_n          = hold_wr ? CMD_WR : CMD_RD;
        ba_n           = hold_bank;
        addr_n         = {{(ADDR_W-COL_W){1'b0}}, hold_col};
        addr_n[AP_BIT] = 1'b1;
        st_n           = S_IDLE;
      end
      S_REF: begin
        cmd_n    = CMD_REF;
        ref_fire = 1'b1;
        st_n     = S_WAIT;
        cnt_n    = CW'(wait_load(T_RC));
        ret_n    = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_PWR;
      ret       <= S_IDLE;
      cnt       <= CW'(INIT_CYCLES - 1);
      cmd_q     <= CMD_NOP;
      ba_q      <= '0;
      addr_q    <= '0;
      cke_q     <= 1'b0;
      init_done <= 1'b0;
      hold_bank <= '0;
      hold_col  <= '0;
      hold_wr   <= 1'b0;
    end else begin
      st        <= st_n;
      ret       <= ret_n;
      cnt       <= cnt_n;
      cmd_q     <= cmd_n;
      ba_q      <= ba_n;
      addr_q    <= addr_n;
      cke_q     <= (st_n != S_PWR);
      init_done <= init_done | mrs_fire;
      if (act_fire) begin
        hold_bank <= req_bank;
        hold_col  <= req_col;
        hold_wr   <= req_write;
      end
    end
  end

  assign sd_cke   = cke_q;
  assign sd_cs_n  = cmd_q[3];
  assign sd_ras_n = cmd_q[2];
  assign sd_cas_n = cmd_q[1];
  assign sd_we_n  = cmd_q[0];
  assign sd_ba    = ba_q;
  assign sd_addr  = addr_q;

  assert_cke_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != CMD_NOP) |-> (cke_q && $past(cke_q))) else $error("command without clock enable lead");

  assert_mrs_banks_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_fire |-> all_idle) else $error("mode set with a bank busy");

  assert_act_bank_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |-> bank_idle[req_bank]) else $error("activate to busy bank");

  assert_act_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |-> rrd_idle) else $error("activate spacing violated");

  assert_ref_banks_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_fire |-> all_idle) else $error("refresh with a bank busy");

  assert_col_autopre_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> addr_q[AP_BIT]) else $error("column command without auto-precharge");

  assert_no_accept_in_refresh_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_all_fire || ref_fire) |-> !act_fire) else $error("activate during refresh");

endmodule

// File: tb/sdram_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module sdram_cmd_ctrl_bench;
  localparam int CL      = 3;
  localparam int T_RCD   = 2;
  localparam int T_RP    = 2;
  localparam int T_RRD   = 2;
  localparam int T_RAS   = 5;
  localparam int T_RC    = 7;
  localparam int T_RDL   = 1;
  localparam int T_MRD   = 2;
  localparam int REFI    = 1562;
  localparam int INIT    = 300;
  localparam int SLACK   = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [11:0] req_row = '0;
  logic [7:0]  req_col = '0;
  logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [11:0] sd_addr;

  always #4 clk = ~clk;

  sdram_cmd_ctrl #(
    .CAS_LAT(CL), .T_RCD(T_RCD), .T_RP(T_RP), .T_RRD(T_RRD), .T_RAS(T_RAS),
    .T_RC(T_RC), .T_RDL(T_RDL), .T_MRD(T_MRD), .REFI(REFI), .INIT_CYCLES(INIT)
  ) u_sdram_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
  );

  int n_chk = 0, n_bad = 0;
  bit reported = 0;
  int cyc = 0;

  function automatic int bank_window();
    int w;
    w = T_RC;
    if (T_RAS + T_RP > w) w = T_RAS + T_RP;
    if (T_RCD + 1 + T_RDL + T_RP > w) w = T_RCD + 1 + T_RDL + T_RP;
    return w;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // expected request stream
  int q_bank[$], q_row[$], q_col[$], q_wr[$], q_cyc[$];

  // monitor state
  int last_act[4] = '{-1000, -1000, -1000, -1000};
  int last_act_any = -1000, last_pre = -1000, last_ref = -1000, last_mrs = -1000;
  int last_any_cmd = -1000;
  int init_idx = 0, cke_cyc = -1, n_ref_run = 0;
  bit prev_cke = 0, open_col = 0;
  int open_bank = 0, open_col_v = 0, open_wr = 0, open_cyc = 0;

  always @(negedge clk) if (rst_n) begin
    logic [2:0] c;
    c = {sd_ras_n, sd_cas_n, sd_we_n};
    if (sd_cke && cke_cyc < 0) begin
      cke_cyc = cyc;
      check(cyc >= INIT, "R2 clock enable low time", cyc, INIT);
    end
    if (c != 3'b111 || sd_cs_n) begin
      check(!sd_cs_n, "R5 chip select low", sd_cs_n, 0);
      check(c != 3'b110, "R5 no burst stop", c, 0);
      check(sd_cke && prev_cke, "R2 clock enable lead", {prev_cke, sd_cke}, 3);
      check(cyc - last_ref >= T_RC, "R11 quiet after refresh", cyc - last_ref, T_RC);
      check(cyc - last_mrs >= T_MRD, "R4 quiet after mode set", cyc - last_mrs, T_MRD);
      if (init_idx < 4) begin
        int want;
        want = (init_idx == 0) ? 3'b010 : (init_idx == 3) ? 3'b000 : 3'b001;
        check(c == 3'(want), "R3 init order", c, want);
        if (init_idx == 0) check(sd_addr[10], "R3 init precharge all", sd_addr[10], 1);
        init_idx++;
      end
      case (c)
        3'b000: begin
          check(sd_addr == 12'(CL << 4) && sd_ba == 0, "R4 mode word", sd_addr, CL << 4);
          last_mrs = cyc;
        end
        3'b001: begin
          check(cyc - last_pre >= T_RP, "R9 refresh after precharge", cyc - last_pre, T_RP);
          if (last_mrs >= 0) begin
            int gap, lo;
            gap = (n_ref_run == 0) ? cyc - last_mrs : cyc - last_ref;
            lo  = (n_ref_run == 0) ? REFI : REFI - SLACK;
            check(gap >= lo && gap <= REFI + SLACK, "R10 refresh interval", gap, REFI);
            n_ref_run++;
          end
          last_ref = cyc;
        end
        3'b010: begin
          check(sd_addr[10], "R9 precharge all banks", sd_addr[10], 1);
          for (int b = 0; b < 4; b++)
            check(cyc - last_act[b] >= bank_window(), "R9 banks closed before precharge",
                  cyc - last_act[b], bank_window());
          last_pre = cyc;
        end
        3'b011: begin
          check(last_mrs >= 0, "R3 no activate before mode set", last_mrs, 0);
          check(cyc - last_act_any >= T_RRD, "R8 activate spacing", cyc - last_act_any, T_RRD);
          check(cyc - last_act[sd_ba] >= bank_window(), "R7 same bank spacing",
                cyc - last_act[sd_ba], bank_window());
          if (q_bank.size() == 0) check(0, "R6 unexpected activate", 1, 0);
          else begin
            check(sd_ba == 2'(q_bank[0]), "R6 activate bank", sd_ba, q_bank[0]);
            check(sd_addr == 12'(q_row[0]), "R6 activate row", sd_addr, q_row[0]);
            check(cyc == q_cyc[0] + 1, "R6 activate cycle", cyc, q_cyc[0] + 1);
            open_col = 1; open_bank = q_bank[0]; open_col_v = q_col[0];
            open_wr = q_wr[0]; open_cyc = cyc;
            void'(q_bank.pop_front()); void'(q_row.pop_front()); void'(q_col.pop_front());
            void'(q_wr.pop_front());   void'(q_cyc.pop_front());
          end
          last_act[sd_ba] = cyc;
          last_act_any = cyc;
        end
        3'b101, 3'b100: begin
          check(open_col, "R6 column without activate", open_col, 1);
          check(cyc - open_cyc == T_RCD, "R6 activate to column", cyc - open_cyc, T_RCD);
          check(sd_ba == 2'(open_bank), "R6 column bank", sd_ba, open_bank);
          check(sd_addr == (12'(open_col_v) | 12'h400), "R6 column address", sd_addr,
                open_col_v | 32'h400);
          check((c == 3'b100) == (open_wr != 0), "R6 read or write", c, open_wr);
          open_col = 0;
        end
        default: ;
      endcase
      last_any_cmd = cyc;
    end
    prev_cke = sd_cke;
  end

  task automatic send(int bank, int row, int col, int wr);
    int waited;
    waited = 0;
    @(negedge clk);
    req_valid = 1'b1; req_bank = 2'(bank); req_row = 12'(row);
    req_col = 8'(col); req_write = wr[0];
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk);
      waited++;
      if (waited > 3000) begin
        check(0, "R6 request never accepted", waited, 0);
        req_valid = 1'b0;
        return;
      end
    end
    q_bank.push_back(bank); q_row.push_back(row); q_col.push_back(col);
    q_wr.push_back(wr); q_cyc.push_back(cyc);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(sd_cke == 0, "R1 clock enable in reset", sd_cke, 0);
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1 idle command in reset",
          {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
    check(req_ready == 0, "R1 not ready in reset", req_ready, 0);
    rst_n = 1'b1;
    // request offered during power-up must wait until after the mode set (R3)
    send(1, 12'h0AB, 8'h12, 1);
    // same bank back to back: R7
    for (int i = 0; i < 30; i++) send(2, i * 37, i, i & 1);
    // bank rotation: R8
    for (int i = 0; i < 40; i++) send(i % 4, 12'hFFF - i, 255 - i, (i >> 1) & 1);
    // random traffic spanning many refresh intervals: R9, R10, R11
    for (int i = 0; i < 3500; i++) begin
      int gap;
      gap = $urandom % 4;
      repeat (gap) @(negedge clk);
      send($urandom % 4, $urandom % 4096, $urandom % 256, $urandom % 2);
    end
    repeat (60) @(negedge clk);
    check(q_bank.size() == 0 && !open_col, "R6 all requests served", q_bank.size(), 0);
    check(n_ref_run >= (cyc - last_mrs) / (REFI + SLACK), "R10 refresh count",
          n_ref_run, (cyc - last_mrs) / (REFI + SLACK));
    report();
  end

  initial begin
    repeat (190000) @(posedge clk);
    check(0, "watchdog expired", cyc, 0);
    report();
  end

endmodule